// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends asynchronous serial frames on a single line. Each frame is a low start bit, eight or nine data bits with the least significant bit first, and a high stop bit, all in NRZ form. A byte written by software goes first into a one-entry holding buffer. From there it moves into an internal frame shifter whenever the shifter is free. The result is that software can queue the next byte while the current frame is still on the line.

Bit timing comes from an 8-bit reload divider. The divider ticks once every divisor+1 system clocks. With the fast select set, sixteen ticks make one bit period; with it clear, sixty-four ticks do. Two status outputs are provided. One is a buffer-empty flag that software cannot clear; only a new write clears it. The other is a polled shifter-empty flag. The line also has an output-enable, so it floats whenever the port or the transmitter is switched off.

Dropping the transmit enable aborts any frame in flight at once and resets the transmitter. When 9-bit frames are selected, the ninth bit is taken from its control input at the moment of transfer into the shifter, not at the moment of the write.

Top module: `sertx_dbuf`

## Requirements
- R1: A frame is a 0 start bit, then the data bits with bit 0 first, then a 1 stop bit; an 8-bit frame is 10 bit periods on the line.
- R2: One bit period lasts (divisor+1)*16 clocks when fast_sel=1 and (divisor+1)*64 clocks when fast_sel=0, and ser_out changes only at bit boundaries.
- R3: The shifter is loaded from the holding buffer only after the previous frame's stop bit period has ended, and only when the buffer holds data; bytes go out in write order.
- R4: A transfer takes one clock: the cycle after it, the buffer is empty and buf_empty=1 while shift_empty=0.
- R5: With tx_on=1, buf_empty falls only after a write to the holding buffer; no other stimulus clears it, and it stays high while nothing is written.
- R6: shift_empty is 1 exactly while the shifter holds no frame.
- R7: A byte written while the shifter is empty moves to the shifter on the next clock, so two clocks after the write strobe buf_empty=1 and shift_empty=0.
- R8: Dropping tx_on during a frame aborts it: from the next clock, ser_oe=0 and shift_empty=1, and no part of the frame is sent after re-enable.
- R9: With nine_bit=1 a frame has 11 bit periods; the ninth data bit follows data bit 7 and takes the value of ninth_val at the transfer cycle, so a change after the transfer is not sent.
- R10: buf_empty reads 0 while tx_on=0. When tx_on rises with an empty buffer, it goes to 1. A byte written while disabled is transferred on the first enabled clock.
- R11: While enabled and idle, the line is driven high. While port_on=0, ser_oe=0 and no byte leaves the holding buffer.
- R12: After reset, shift_empty=1, ser_out=1 and the holding buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to place in the holding buffer |
| tx_on | input | 1 | Transmit enable; low aborts and resets the transmitter |
| port_on | input | 1 | Serial port enable; low floats the line |
| nine_bit | input | 1 | Selects 9-bit data frames |
| ninth_val | input | 1 | Value sent as the ninth data bit |
| fast_sel | input | 1 | 1: 16 divider ticks per bit, 0: 64 |
| divisor | input | 8 | Divider reload value; tick every divisor+1 clocks |
| buf_empty | output | 1 | Holding buffer empty flag, gated by tx_on |
| shift_empty | output | 1 | Shifter holds no frame |
| ser_out | output | 1 | Serial line value |
| ser_oe | output | 1 | Line output-enable |

## Verification
The frame path is swept over all 256 byte values, back to back, at the shortest bit period. This shows that bit order and data bits are correct and that queued bytes never overtake or overwrite one another. Eight divider settings are then run, covering both oversampling ratios, with 8-bit and 9-bit frames mixed in. The low time of the start bit is measured on bytes whose bit 0 is 1, so a wrong ratio or a wrong divider count shows up as a wrong period length. Separate patterns cover three cases: a late change of the ninth bit against a stale one, a write made while disabled against one made while enabled, and a mid-frame abort against a clean stop. Each pattern separates buffer timing from shifter timing.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    parameter int DATA_W  = 8;
    parameter int FRAME_W = DATA_W + 3;
    parameter int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_ARMED = 2'd1,
        SH_SEND  = 2'd2
    } sh_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [CNT_W-1:0]   len;
    } frame_t;

    function automatic frame_t pack_frame(logic [DATA_W-1:0] d, logic nine, logic b9);
        frame_t f;
        f.bits = {1'b1, (nine ? b9 : 1'b1), d, 1'b0};
        f.len  = nine ? CNT_W'(DATA_W + 3) : CNT_W'(DATA_W + 2);
        return f;
    endfunction
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int DIV_W   = 8,
    parameter int OS_FAST = 16,
    parameter int OS_SLOW = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             fast,
    input  logic [DIV_W-1:0] divisor,
    output logic             bit_stb
);
    localparam int OS_W = $clog2(OS_SLOW);

    logic [DIV_W-1:0] cnt;
    logic [OS_W-1:0]  os_cnt;
    logic             tick;
    logic             os_last;

    assign tick    = run && (cnt == '0);
    assign os_last = fast ? (os_cnt == OS_W'(OS_FAST - 1)) : (os_cnt == OS_W'(OS_SLOW - 1));
    assign bit_stb = tick && os_last;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt    <= divisor;
            os_cnt <= '0;
        end else if (tick) begin
            cnt    <= divisor;
            os_cnt <= os_last ? '0 : os_cnt + 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (wr_en) begin
                data <= wr_data;
                full <= 1'b1;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   bit_stb,
    input  logic   load,
    input  frame_t load_frame,
    output logic   line,
    output logic   empty
);
    sh_state_e          state;
    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   left;

    assign empty = (state == SH_IDLE);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state <= SH_IDLE;
            sr    <= '1;
            left  <= '0;
            line  <= 1'b1;
        end else begin
            case (state)
                SH_IDLE: if (load) begin
                    sr    <= load_frame.bits;
                    left  <= load_frame.len;
                    state <= SH_ARMED;
                end
                SH_ARMED: if (bit_stb) begin
                    line  <= sr[0];
                    sr    <= {1'b1, sr[FRAME_W-1:1]};
                    left  <= left - 1'b1;
                    state <= SH_SEND;
                end
                SH_SEND: if (bit_stb) begin
                    if (left == '0) begin
                        state <= SH_IDLE;
                    end else begin
                        line <= sr[0];
                        sr   <= {1'b1, sr[FRAME_W-1:1]};
                        left <= left - 1'b1;
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf
    import sertx_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int OS_FAST = 16,
    parameter int OS_SLOW = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_on,
    input  logic              port_on,
    input  logic              nine_bit,
    input  logic              ninth_val,
    input  logic              fast_sel,
    input  logic [DIV_W-1:0]  divisor,
    output logic              buf_empty,
    output logic              shift_empty,
    output logic              ser_out,
    output logic              ser_oe
);
    logic              run;
    logic              bit_stb;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    frame_t            next_frame;

    assign run        = tx_on && port_on;
    assign take       = run && hold_full && shift_empty;
    assign next_frame = pack_frame(hold_data, nine_bit, ninth_val);
    assign buf_empty  = tx_on && !hold_full;
    assign ser_oe     = run;

    sertx_baud #(.DIV_W(DIV_W), .OS_FAST(OS_FAST), .OS_SLOW(OS_SLOW)) u_baud (
        .clk(clk), .rst(rst), .run(run), .fast(fast_sel),
        .divisor(divisor), .bit_stb(bit_stb)
    );

    sertx_holdbuf #(.W(DATA_W)) u_hold (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .take(take), .full(hold_full), .data(hold_data)
    );

    sertx_shifter u_shift (
        .clk(clk), .rst(rst), .run(run), .bit_stb(bit_stb),
        .load(take), .load_frame(next_frame),
        .line(ser_out), .empty(shift_empty)
    );
endmodule

// File: rtl/sertx_dbuf_chk.sv
module sertx_dbuf_chk (
    input logic clk,
    input logic rst,
    input logic tx_on,
    input logic port_on,
    input logic wr_en,
    input logic ser_out,
    input logic ser_oe,
    input logic buf_empty,
    input logic shift_empty,
    input logic bit_stb,
    input logic hold_full
);
    p_line_on_boundary_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(ser_out) |-> ($past(bit_stb) || !$past(tx_on) || !$past(port_on)));

    p_load_needs_data_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_empty) |-> $past(hold_full));

    p_load_empties_buf_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(shift_empty) && !$past(wr_en)) |-> !hold_full);

    p_flag_write_only_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(buf_empty) |-> ($past(wr_en) || !tx_on));

    p_abort_floats_r8: assert property (@(posedge clk) disable iff (rst)
        (!tx_on && $past(!tx_on)) |-> (shift_empty && !ser_oe));

    p_idle_high_r11: assert property (@(posedge clk) disable iff (rst)
        (shift_empty && $past(shift_empty)) |-> ser_out);
endmodule

bind sertx_dbuf sertx_dbuf_chk u_chk (
    .clk(clk), .rst(rst), .tx_on(tx_on), .port_on(port_on), .wr_en(wr_en),
    .ser_out(ser_out), .ser_oe(ser_oe), .buf_empty(buf_empty),
    .shift_empty(shift_empty), .bit_stb(bit_stb), .hold_full(hold_full)
);

// File: tb/sertx_dbuf_bench.sv
`timescale 1ns/1ps
module sertx_dbuf_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tx_on = 1'b0;
    logic       port_on = 1'b0;
    logic       nine_bit = 1'b0;
    logic       ninth_val = 1'b0;
    logic       fast_sel = 1'b1;
    logic [7:0] divisor = '0;
    logic       buf_empty, shift_empty, ser_out, ser_oe;

    int total = 0;
    int bad = 0;
    int per = 16;
    int nbits = 10;
    int exp_q[$];
    int rx_q[$];
    int slen_q[$];
    int fmt_q[$];

    always #2 clk = ~clk;

    sertx_dbuf u_sertx_dbuf (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .tx_on(tx_on), .port_on(port_on), .nine_bit(nine_bit),
        .ninth_val(ninth_val), .fast_sel(fast_sel), .divisor(divisor),
        .buf_empty(buf_empty), .shift_empty(shift_empty),
        .ser_out(ser_out), .ser_oe(ser_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // line monitor: samples mid-bit, measures start-bit low time
    initial begin
        int val, slen, ok, fmt, nb, k;
        bit open;
        forever begin
            @(negedge clk);
            if (ser_oe && ser_out == 1'b0) begin
                val = 0; slen = 1; ok = 1; fmt = 1; open = 1'b1; nb = nbits;
                for (int i = 1; i <= (nb - 1) * per + per / 2; i++) begin
                    @(negedge clk);
                    if (!ser_oe) ok = 0;
                    if (open) begin
                        if (ser_out == 1'b0) slen++;
                        else open = 1'b0;
                    end
                    if (i % per == per / 2) begin
                        k = i / per;
                        if (k == 0) begin
                            if (ser_out != 1'b0) fmt = 0;
                        end else if (k == nb - 1) begin
                            if (ser_out != 1'b1) fmt = 0;
                        end else begin
                            val = val | (int'(ser_out) << (k - 1));
                        end
                    end
                end
                if (ok != 0) begin
                    rx_q.push_back(val);
                    slen_q.push_back(slen);
                    fmt_q.push_back(fmt);
                end
            end
        end
    end

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_queued(input logic [7:0] b);
        while (!buf_empty) @(negedge clk);
        write_byte(b);
        exp_q.push_back(int'(b) | ((nine_bit && ninth_val) ? 256 : 0));
    endtask

    task automatic cfg(input logic f, input logic [7:0] d, input logic nine);
        @(negedge clk);
        tx_on = 1'b0;
        fast_sel = f;
        divisor = d;
        nine_bit = nine;
        per = (int'(d) + 1) * (f ? 16 : 64);
        nbits = nine ? 11 : 10;
        @(negedge clk);
        tx_on = 1'b1;
        @(negedge clk);
    endtask

    task automatic drain(input string req);
        do @(negedge clk); while (!(shift_empty && buf_empty));
        repeat (2 * per) @(negedge clk);
        chk(rx_q.size() == exp_q.size(), "R3 frame count", rx_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++) begin
            chk(rx_q[i] == exp_q[i], req, rx_q[i], exp_q[i]);
            chk(fmt_q[i] == 1, "R1 start/stop", fmt_q[i], 1);
            if (exp_q[i] % 2 == 1)
                chk(slen_q[i] == per, "R2 bit period", slen_q[i], per);
        end
        exp_q.delete(); rx_q.delete(); slen_q.delete(); fmt_q.delete();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lows;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(shift_empty == 1'b1, "R12 shift_empty", shift_empty, 1);
        chk(ser_out == 1'b1, "R12 ser_out", ser_out, 1);
        chk(ser_oe == 1'b0, "R12 ser_oe", ser_oe, 0);
        chk(buf_empty == 1'b0, "R10 flag masked while off", buf_empty, 0);
        port_on = 1'b1;

        // full byte sweep, back to back, shortest period
        cfg(1'b1, 8'd0, 1'b0);
        chk(buf_empty == 1'b1, "R10 flag on enable", buf_empty, 1);
        chk(ser_out == 1'b1 && ser_oe == 1'b1, "R11 idle high", ser_out, 1);
        chk(shift_empty == 1'b1, "R6 idle shifter", shift_empty, 1);
        for (int b = 0; b < 256; b++) begin
            send_queued(8'(b));
            if (b == 1) begin
                chk(buf_empty == 1'b0, "R3 buffer holds behind busy shifter", buf_empty, 0);
                chk(shift_empty == 1'b0, "R6 shifter busy", shift_empty, 0);
            end
        end
        drain("R1 data");

        // divider and ratio sweep, mixed frame widths
        for (int f = 0; f < 2; f++) begin
            for (int d = 0; d < 4; d++) begin
                cfg(1'(f), 8'(d), 1'(d % 2));
                ninth_val = 1'(f);
                send_queued(8'h35 ^ 8'(d << 4));
                send_queued(8'hCB ^ 8'(d << 5));
                drain("R9 data across configs");
            end
        end

        // ninth bit captured at transfer; R7 immediate move
        cfg(1'b1, 8'd1, 1'b1);
        ninth_val = 1'b0;
        write_byte(8'h5C);
        exp_q.push_back(8'h5C);
        @(negedge clk);
        chk(buf_empty == 1'b1, "R7 buffer empty after move", buf_empty, 1);
        chk(shift_empty == 1'b0, "R4 shifter loaded", shift_empty, 0);
        ninth_val = 1'b1;
        write_byte(8'hA3);
        exp_q.push_back(8'hA3);
        ninth_val = 1'b0;
        drain("R9 ninth bit at transfer");

        // R5 flag stays set with no write
        lows = 0;
        repeat (400) begin
            @(negedge clk);
            if (!buf_empty) lows++;
        end
        chk(lows == 0, "R5 flag held without write", lows, 0);

        // R10 write while disabled, then enable
        @(negedge clk);
        tx_on = 1'b0;
        write_byte(8'h97);
        chk(buf_empty == 1'b0, "R10 flag low while off", buf_empty, 0);
        chk(shift_empty == 1'b1, "R10 no transfer while off", shift_empty, 1);
        tx_on = 1'b1;
        exp_q.push_back(8'h97 | 256 * 0);
        @(negedge clk);
        chk(buf_empty == 1'b1 && shift_empty == 1'b0, "R10 transfer on enable", buf_empty, 1);
        drain("R10 data");

        // R11 port disabled: floats, nothing leaves buffer
        @(negedge clk);
        port_on = 1'b0;
        @(negedge clk);
        chk(ser_oe == 1'b0, "R11 float when port off", ser_oe, 0);
        write_byte(8'h3D);
        repeat (50) @(negedge clk);
        chk(shift_empty == 1'b1, "R11 no transfer when port off", shift_empty, 1);
        chk(buf_empty == 1'b0, "R5 write clears flag", buf_empty, 0);
        port_on = 1'b1;
        exp_q.push_back(8'h3D);
        drain("R11 data after port on");

        // R8 abort mid frame
        cfg(1'b1, 8'd0, 1'b0);
        write_byte(8'h00);
        repeat (3 * per) @(negedge clk);
        tx_on = 1'b0;
        @(negedge clk);
        chk(ser_oe == 1'b0, "R8 float on abort", ser_oe, 0);
        chk(shift_empty == 1'b1, "R8 shifter reset", shift_empty, 1);
        repeat (12 * per) @(negedge clk);
        tx_on = 1'b1;
        @(negedge clk);
        chk(ser_out == 1'b1 && ser_oe == 1'b1, "R8 idle after re-enable", ser_out, 1);
        chk(shift_empty == 1'b1 && buf_empty == 1'b1, "R8 nothing pending", shift_empty, 1);
        repeat (15 * per) @(negedge clk);
        chk(rx_q.size() == 0, "R8 no frame after abort", rx_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule